// File: doc/BRIEF.md
# Sensitive Instruction Trap Filter

This block sits beside the decode stage of a processor that has to be fully virtualizable. For each decoded instruction it receives an instruction-group code, the current privilege level (0 is the most privileged, 3 the least) and a bit that says whether a hypervisor is running the code as a de-privileged guest. From these inputs it chooses one of three actions: execute normally, raise a general protection fault, or raise a trap to the hypervisor.

In legacy mode (guest bit clear), the block behaves as a classic ring machine. Privileged groups fault when run above level 0. Groups that are sensitive but unprivileged execute silently. These groups are descriptor-table and task register stores, the status-word store, flag pops, reads or pushes of the code and stack selectors, cross-level far calls and task switches.

In guest mode, every sensitive or privileged group traps to the hypervisor whenever the privilege level is not 0. This closes the gap left by instructions that change or reveal privileged state without trapping. The decision is registered and presented one cycle after the decode strobe, together with a cause code and a stall/flush request.

Top module: `sit_trap_filter`

## Requirements
- R1: While reset is high, and on the first clock edge after reset, the action is execute (2'b00), the cause is 0 and stall/flush is low.
- R2: A cycle with no valid strobe produces execute with cause 0 on the next clock edge, whatever group, privilege level or mode is presented.
- R3: At privilege level 0, every group executes (action 2'b00, cause 0) in both modes.
- R4: In legacy mode, the privileged groups run at privilege level 1, 2 or 3 give a general protection fault (action 2'b01), and the cause equals the group code. The privileged groups are 1 (load descriptor-table or task register) and 2 (other privileged operation).
- R5: In guest mode, the privileged groups 1 and 2 run at privilege level 1, 2 or 3 give a hypervisor trap (action 2'b10), and the cause equals the group code.
- R6: In guest mode, the sensitive unprivileged groups run at privilege level 1, 2 or 3 give a hypervisor trap (action 2'b10), and the cause equals the group code. These groups are 3 (table/task register store), 4 (status-word store), 5 (flag pop), 6 (code/stack selector read or push), 9 (far call to another level) and 10 (task switch).
- R7: In legacy mode, the sensitive unprivileged groups 3, 4, 5, 6, 9 and 10 execute at any privilege level, and the legacy mode never produces action 2'b10.
- R8: Non-sensitive groups execute in every mode and at every level. These are 0 (plain), 7 (near call), 8 (far call at the same level) and 11 to 15.
- R9: The result for a valid strobe appears on the first clock edge after the strobe. Back-to-back strobes each produce their own result in successive cycles, and stall/flush is high exactly when the action is not execute.
- R10: Whenever the action is execute, the cause is 0. The action code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction present this cycle |
| dec_group | input | 4 | Instruction group code |
| cur_pl | input | 2 | Current privilege level, 0 most privileged |
| guest_on | input | 1 | 1 = running as a de-privileged guest |
| act_code | output | 2 | 00 execute, 01 protection fault, 10 hypervisor trap |
| cause_code | output | 4 | Group code of the faulting or trapping instruction, else 0 |
| stall_flush | output | 1 | Stall and flush request, high when the action is not execute |

## Verification
Every result of this block is due exactly one clock edge after the inputs that caused it. The bench drives each input on a falling edge and reads the outputs on the next falling edge, so each reading reflects only the edge in between. A separate latency check reads the outputs once before the edge, to confirm they have not yet moved, and once after it. Back-to-back strobes in the vector walk confirm that each result follows its own strobe by one cycle and never lasts into the next.

// File: rtl/sit_pkg.sv
package sit_pkg;
  typedef enum logic [1:0] {
    ACT_EXEC   = 2'b00,
    ACT_GP     = 2'b01,
    ACT_VMTRAP = 2'b10
  } act_e;
endpackage

// File: rtl/sit_group_lut.sv
module sit_group_lut #(
  parameter int CLASS_W = 4,
  parameter logic [(1<<CLASS_W)-1:0] PRIV_MASK = '0,
  parameter logic [(1<<CLASS_W)-1:0] SENS_MASK = '0
) (
  input  logic [CLASS_W-1:0] grp,
  output logic               is_priv,
  output logic               is_sens
);
  localparam int NGRP = 1 << CLASS_W;

  logic [NGRP-1:0] priv_v;
  logic [NGRP-1:0] sens_v;

  // One entry per group; a group marked privileged is also treated as sensitive.
  for (genvar g = 0; g < NGRP; g++) begin : g_entry
    assign priv_v[g] = PRIV_MASK[g];
    assign sens_v[g] = SENS_MASK[g] | PRIV_MASK[g];
  end

  assign is_priv = priv_v[grp];
  assign is_sens = sens_v[grp];
endmodule

// File: rtl/sit_decide.sv
module sit_decide
  import sit_pkg::*;
#(
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2
) (
  input  logic               valid,
  input  logic [CLASS_W-1:0] grp,
  input  logic [PL_W-1:0]    pl,
  input  logic               guest,
  input  logic               is_priv,
  input  logic               is_sens,
  output act_e               act_nxt,
  output logic [CLASS_W-1:0] cause_nxt
);
  logic deprivileged;
  assign deprivileged = (pl != '0);

  always_comb begin
    act_nxt   = ACT_EXEC;
    cause_nxt = '0;
    if (valid && deprivileged) begin
      if (guest && is_sens) begin
        act_nxt   = ACT_VMTRAP;
        cause_nxt = grp;
      end else if (!guest && is_priv) begin
        act_nxt   = ACT_GP;
        cause_nxt = grp;
      end
    end
  end
endmodule

// File: rtl/sit_out_reg.sv
module sit_out_reg
  import sit_pkg::*;
#(
  parameter int CLASS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  act_e               act_nxt,
  input  logic [CLASS_W-1:0] cause_nxt,
  output logic [1:0]         act_q,
  output logic [CLASS_W-1:0] cause_q,
  output logic               flush_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= ACT_EXEC;
      cause_q <= '0;
      flush_q <= 1'b0;
    end else begin
      act_q   <= act_nxt;
      cause_q <= cause_nxt;
      flush_q <= (act_nxt != ACT_EXEC);
    end
  end
endmodule

// File: rtl/sit_trap_filter.sv
module sit_trap_filter
  import sit_pkg::*;
#(
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2,
  parameter logic [(1<<CLASS_W)-1:0] PRIV_MASK = 16'h0006,
  parameter logic [(1<<CLASS_W)-1:0] SENS_MASK = 16'h0678
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_valid,
  input  logic [CLASS_W-1:0] dec_group,
  input  logic [PL_W-1:0]    cur_pl,
  input  logic               guest_on,
  output logic [1:0]         act_code,
  output logic [CLASS_W-1:0] cause_code,
  output logic               stall_flush
);
  logic               is_priv;
  logic               is_sens;
  act_e               act_nxt;
  logic [CLASS_W-1:0] cause_nxt;

  sit_group_lut #(
    .CLASS_W  (CLASS_W),
    .PRIV_MASK(PRIV_MASK),
    .SENS_MASK(SENS_MASK)
  ) lut_i (
    .grp    (dec_group),
    .is_priv(is_priv),
    .is_sens(is_sens)
  );

  sit_decide #(
    .CLASS_W(CLASS_W),
    .PL_W   (PL_W)
  ) dec_i (
    .valid    (dec_valid),
    .grp      (dec_group),
    .pl       (cur_pl),
    .guest    (guest_on),
    .is_priv  (is_priv),
    .is_sens  (is_sens),
    .act_nxt  (act_nxt),
    .cause_nxt(cause_nxt)
  );

  sit_out_reg #(
    .CLASS_W(CLASS_W)
  ) oreg_i (
    .clk      (clk),
    .rst      (rst),
    .act_nxt  (act_nxt),
    .cause_nxt(cause_nxt),
    .act_q    (act_code),
    .cause_q  (cause_code),
    .flush_q  (stall_flush)
  );
endmodule

// File: rtl/sit_trap_filter_chk.sv
module sit_trap_filter_chk #(
  parameter int CLASS_W = 4,
  parameter int PL_W    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               dec_valid,
  input logic [CLASS_W-1:0] dec_group,
  input logic [PL_W-1:0]    cur_pl,
  input logic               guest_on,
  input logic [1:0]         act_code,
  input logic [CLASS_W-1:0] cause_code,
  input logic               stall_flush
);
  // R2
  idle_exec_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> (act_code == 2'b00 && cause_code == '0));

  // R3
  top_level_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cur_pl == '0) |=> (act_code == 2'b00));

  // R7
  legacy_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !guest_on) |=> (act_code != 2'b10));

  // R5
  guest_no_gp_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && guest_on) |=> (act_code != 2'b01));

  // R9
  flush_match_chk: assert property (@(posedge clk) disable iff (rst)
    stall_flush == (act_code != 2'b00));

  // R10
  exec_zero_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == 2'b00) |-> (cause_code == '0));

  // R10
  no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    act_code != 2'b11);

  // R4
  cause_tracks_group_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> (act_code == 2'b00 || cause_code == $past(dec_group)));
endmodule

bind sit_trap_filter sit_trap_filter_chk #(
  .CLASS_W(CLASS_W),
  .PL_W   (PL_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dec_valid  (dec_valid),
  .dec_group  (dec_group),
  .cur_pl     (cur_pl),
  .guest_on   (guest_on),
  .act_code   (act_code),
  .cause_code (cause_code),
  .stall_flush(stall_flush)
);

// File: tb/sit_trap_filter_tb_top.sv
module sit_trap_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [3:0] dec_group = '0;
  logic [1:0] cur_pl = '0;
  logic       guest_on = 1'b0;
  logic [1:0] act_code;
  logic [3:0] cause_code;
  logic       stall_flush;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sit_trap_filter dut_i (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_group(dec_group),
    .cur_pl(cur_pl), .guest_on(guest_on), .act_code(act_code),
    .cause_code(cause_code), .stall_flush(stall_flush)
  );

  // {valid, group, level, guest, expected action, expected cause}
  localparam int NV = 20;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 4'd1,  2'd3, 1'b0, 2'd1, 4'd1},
    {1'b1, 4'd1,  2'd3, 1'b1, 2'd2, 4'd1},
    {1'b1, 4'd1,  2'd0, 1'b1, 2'd0, 4'd0},
    {1'b1, 4'd2,  2'd1, 1'b0, 2'd1, 4'd2},
    {1'b1, 4'd2,  2'd2, 1'b1, 2'd2, 4'd2},
    {1'b1, 4'd3,  2'd3, 1'b1, 2'd2, 4'd3},
    {1'b1, 4'd3,  2'd3, 1'b0, 2'd0, 4'd0},
    {1'b1, 4'd4,  2'd2, 1'b1, 2'd2, 4'd4},
    {1'b1, 4'd5,  2'd3, 1'b1, 2'd2, 4'd5},
    {1'b1, 4'd5,  2'd0, 1'b1, 2'd0, 4'd0},
    {1'b1, 4'd5,  2'd3, 1'b0, 2'd0, 4'd0},
    {1'b1, 4'd6,  2'd3, 1'b1, 2'd2, 4'd6},
    {1'b1, 4'd7,  2'd3, 1'b1, 2'd0, 4'd0},
    {1'b1, 4'd8,  2'd3, 1'b1, 2'd0, 4'd0},
    {1'b1, 4'd9,  2'd3, 1'b1, 2'd2, 4'd9},
    {1'b1, 4'd10, 2'd1, 1'b1, 2'd2, 4'd10},
    {1'b1, 4'd10, 2'd1, 1'b0, 2'd0, 4'd0},
    {1'b1, 4'd0,  2'd3, 1'b1, 2'd0, 4'd0},
    {1'b0, 4'd1,  2'd3, 1'b1, 2'd0, 4'd0},
    {1'b1, 4'd15, 2'd3, 1'b1, 2'd0, 4'd0}
  };

  function automatic string req_of(logic v, logic [3:0] g, logic [1:0] p, logic gu);
    if (!v) return "R2";
    if (p == 2'd0) return "R3";
    if (g == 4'd1 || g == 4'd2) return gu ? "R5" : "R4";
    if (g inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10}) return gu ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic check(string req, logic [1:0] ea, logic [3:0] ec);
    n_checks++;
    if (act_code !== ea || cause_code !== ec || stall_flush !== (ea != 2'd0)) begin
      n_errors++;
      $display("FAIL %s: act=%0d cause=%0d flush=%0b expected act=%0d cause=%0d flush=%0b",
               req, act_code, cause_code, stall_flush, ea, ec, (ea != 2'd0));
    end
  endtask

  task automatic drive(logic v, logic [3:0] g, logic [1:0] p, logic gu);
    dec_valid = v; dec_group = g; cur_pl = p; guest_on = gu;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: act=%0d cause=%0d expected run completion", act_code, cause_code);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset, with a faulting pattern on the inputs
    drive(1'b1, 4'd1, 2'd3, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", 2'd0, 4'd0);
    drive(1'b0, 4'd0, 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 2'd0, 4'd0);

    // Vector walk, back-to-back strobes (R2..R8, R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12:9], VEC[i][8:7], VEC[i][6]);
      @(negedge clk);
      check(req_of(VEC[i][13], VEC[i][12:9], VEC[i][8:7], VEC[i][6]),
            VEC[i][5:4], VEC[i][3:0]);
    end

    // R9: result does not appear before the edge, appears right after it
    drive(1'b0, 4'd0, 2'd0, 1'b0);
    @(negedge clk);
    drive(1'b1, 4'd4, 2'd3, 1'b1);
    #1;
    check("R9", 2'd0, 4'd0);
    @(negedge clk);
    check("R9", 2'd2, 4'd4);
    drive(1'b0, 4'd4, 2'd3, 1'b1);
    @(negedge clk);
    check("R2", 2'd0, 4'd0);

    // R3: level 0 in legacy mode with a privileged group
    drive(1'b1, 4'd2, 2'd0, 1'b0);
    @(negedge clk);
    check("R3", 2'd0, 4'd0);

    // R8: far call at same level, legacy mode, level 2
    drive(1'b1, 4'd8, 2'd2, 1'b0);
    @(negedge clk);
    check("R8", 2'd0, 4'd0);

    // R1: reset asserted while a trap is showing clears it
    drive(1'b1, 4'd6, 2'd3, 1'b1);
    @(negedge clk);
    check("R6", 2'd2, 4'd6);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 2'd0, 4'd0);
    rst = 1'b0;
    drive(1'b0, 4'd0, 2'd0, 1'b0);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule